// File: doc/BRIEF.md
# Power Mode and Core Clock Divider Controller

This block holds one 8-bit control register that software writes to switch power domains on and off and to choose the speed of the core clock. Three domain enables are driven straight from the register: processor core, peripheral group and PLL. Two oscillator enables are driven the same way: a precision low-frequency input and a crystal circuit. A 3-bit code selects the core clock as the master clock divided by 2^N. The core clock is delivered as a one-cycle enable strobe in the master clock domain.

Domains may only be shut down in safe combinations. The peripheral group goes down only together with the core. The PLL goes down only together with both. If a write breaks these rules, its domain bits are discarded, and the oscillator and divider fields of that write still take effect. A wake-up event turns all three domains back on in hardware, and the wake-up input keeps working while the peripherals are off. When software turns the core off, the core enable output stays high for one more master cycle, so that a final dummy core cycle can complete.

Top module: `pwr_clk_ctrl`

## Requirements
- R1: While reset is low and directly after it, the register reads 0x79 and the enables for crystal, PLL, peripheral and core are high. The precision oscillator enable is low and the divider code is 1.
- R2: Register bit 7 drives the precision oscillator enable, bit 6 the crystal enable, bit 5 the PLL enable, bit 4 the peripheral enable and bit 3 the core enable. Bits 2:0 hold the divider code.
- R3: A write that takes bit 4 from 1 to 0 while writing bit 3 as 1 is illegal. A write that clears bit 4 and bit 3 together is accepted.
- R4: A write that takes bit 5 from 1 to 0 while writing bit 4 or bit 3 as 1 is illegal.
- R5: An illegal write leaves bits 5:3 unchanged and still updates bits 7, 6 and 2:0.
- R6: A wake-up pulse sets bits 5:3 in the cycle after it is seen. This holds even when the peripheral enable is low.
- R7: When a wake-up and a write arrive in the same cycle, bits 5:3 become 1. Bits 7, 6 and 2:0 take the written values.
- R8: When bit 3 goes from 1 to 0, the core enable output falls one master cycle after the register bit does. When bit 3 is set, the output rises in the same cycle as the register bit.
- R9: With divider code N held, the core clock strobe is high for one master cycle out of every 2^N. With code 0 it is high on every cycle.
- R10: When the divider code changes, the strobe is low in the cycle in which the new code first appears. The count then restarts, and the first strobe comes 2^N cycles after that cycle.
- R11: The strobe is low whenever the core enable output is low.
- R12: The read port always returns the current register contents, including bits set by a wake-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| wake_i | input | 1 | Wake-up event, one cycle or longer |
| rd_data_o | output | 8 | Current register contents |
| prec_osc_en_o | output | 1 | Precision low-frequency oscillator input enable |
| xtal_en_o | output | 1 | Crystal circuit enable |
| pll_en_o | output | 1 | PLL domain enable |
| periph_en_o | output | 1 | Peripheral domain enable |
| core_en_o | output | 1 | Core domain enable, with delayed fall |
| core_clk_en_o | output | 1 | Divided core clock enable strobe |

## Verification
On every cycle, the assertions check the following. A domain bit may only fall in a legal combination. A wake-up must leave bits 5:3 set. The core enable output must never fall in the same cycle as the register bit. A strobe must never fire while the core is off or when the divider code has just changed. With code 0 and the core on, the strobe must be continuous. Only the bench scenarios can show three further things. The first is that an illegal write still applies its oscillator and divider fields. The second is the exact values when a write and a wake-up collide. The third is that the strobe period and its restart point match 2^N for each code. The bench's reference model checks these on every clock.

// File: rtl/pwr_clk_pkg.sv
package pwr_clk_pkg;

  localparam int DIV_W = 3;
  localparam int CNT_W = (1 << DIV_W) - 1;

  typedef struct packed {
    logic             prec_osc;
    logic             xtal;
    logic             pll;
    logic             periph;
    logic             core;
    logic [DIV_W-1:0] div;
  } pwr_reg_t;

  // domain shutdown interlock: periph needs core off, pll needs both off
  function automatic logic domain_write_ok(pwr_reg_t cur, pwr_reg_t nxt);
    logic periph_drop;
    logic pll_drop;
    periph_drop = cur.periph & ~nxt.periph;
    pll_drop    = cur.pll & ~nxt.pll;
    return !((periph_drop && nxt.core) || (pll_drop && (nxt.core || nxt.periph)));
  endfunction

endpackage

// File: rtl/pwr_reg_file.sv
module pwr_reg_file
  import pwr_clk_pkg::*;
#(
  parameter logic [7:0] RST_VAL = 8'h79
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     wr_en_i,
  input  pwr_reg_t wr_data_i,
  input  logic     wake_i,
  output pwr_reg_t reg_o
);

  pwr_reg_t reg_q, reg_d;
  logic     legal;

  assign legal = domain_write_ok(reg_q, wr_data_i);

  always_comb begin
    reg_d = reg_q;
    if (wr_en_i) begin
      reg_d.prec_osc = wr_data_i.prec_osc;
      reg_d.xtal     = wr_data_i.xtal;
      reg_d.div      = wr_data_i.div;
      if (legal) begin
        reg_d.pll    = wr_data_i.pll;
        reg_d.periph = wr_data_i.periph;
        reg_d.core   = wr_data_i.core;
      end
    end
    // wake-up wins over any write for the domain bits
    if (wake_i) begin
      reg_d.pll    = 1'b1;
      reg_d.periph = 1'b1;
      reg_d.core   = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) reg_q <= pwr_reg_t'(RST_VAL);
    else         reg_q <= reg_d;
  end

  assign reg_o = reg_q;

endmodule

// File: rtl/core_gate_delay.sv
module core_gate_delay #(
  parameter int  DLY     = 1,
  parameter logic RST_ON = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic core_req_i,
  output logic core_en_o
);

  logic [DLY-1:0] hist_q;

  generate
    if (DLY == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) hist_q <= RST_ON;
        else         hist_q <= core_req_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) hist_q <= {DLY{RST_ON}};
        else         hist_q <= {hist_q[DLY-2:0], core_req_i};
      end
    end
  endgenerate

  // rise at once, fall only after DLY further cycles
  assign core_en_o = core_req_i | (|hist_q);

endmodule

// File: rtl/clk_div_strobe.sv
module clk_div_strobe
  import pwr_clk_pkg::*;
#(
  parameter logic [DIV_W-1:0] RST_DIV = 3'd1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             run_i,
  output logic             strobe_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;
  logic [DIV_W-1:0] div_last_q;
  logic             div_chg;
  logic             at_limit;

  // limit = 2^div - 1 as a thermometer mask
  generate
    for (genvar i = 0; i < CNT_W; i++) begin : g_lim
      assign limit[i] = (i < int'(div_i));
    end
  endgenerate

  assign div_chg  = (div_i != div_last_q);
  assign at_limit = (cnt_q == limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      div_last_q <= RST_DIV;
    end else begin
      div_last_q <= div_i;
      if (div_chg || at_limit) cnt_q <= '0;
      else                     cnt_q <= cnt_q + 1'b1;
    end
  end

  assign strobe_o = at_limit & ~div_chg & run_i;

endmodule

// File: rtl/pwr_clk_ctrl.sv
module pwr_clk_ctrl
  import pwr_clk_pkg::*;
#(
  parameter logic [7:0] RST_VAL  = 8'h79,
  parameter int         CORE_DLY = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  input  logic       wake_i,
  output logic [7:0] rd_data_o,
  output logic       prec_osc_en_o,
  output logic       xtal_en_o,
  output logic       pll_en_o,
  output logic       periph_en_o,
  output logic       core_en_o,
  output logic       core_clk_en_o
);

  localparam pwr_reg_t RST_REG = pwr_reg_t'(RST_VAL);

  pwr_reg_t cfg;

  pwr_reg_file #(.RST_VAL(RST_VAL)) u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (pwr_reg_t'(wr_data_i)),
    .wake_i    (wake_i),
    .reg_o     (cfg)
  );

  core_gate_delay #(.DLY(CORE_DLY), .RST_ON(RST_REG.core)) u_core_dly (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .core_req_i (cfg.core),
    .core_en_o  (core_en_o)
  );

  clk_div_strobe #(.RST_DIV(RST_REG.div)) u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .div_i    (cfg.div),
    .run_i    (core_en_o),
    .strobe_o (core_clk_en_o)
  );

  assign rd_data_o     = cfg;
  assign prec_osc_en_o = cfg.prec_osc;
  assign xtal_en_o     = cfg.xtal;
  assign pll_en_o      = cfg.pll;
  assign periph_en_o   = cfg.periph;

endmodule

// File: rtl/pwr_clk_ctrl_chk.sv
module pwr_clk_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wake_i,
  input logic [7:0] rd_data_o,
  input logic       core_en_o,
  input logic       core_clk_en_o
);

  AST_WAKE_RESTORES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_i |=> rd_data_o[5:3] == 3'b111); // R6

  AST_PERIPH_INTERLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rd_data_o[4]) |-> !rd_data_o[3]); // R3

  AST_PLL_INTERLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rd_data_o[5]) |-> (!rd_data_o[4] && !rd_data_o[3])); // R4

  AST_CORE_HOLDS_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rd_data_o[3]) |-> core_en_o); // R8

  AST_CORE_FALL_LATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(core_en_o) |-> (!rd_data_o[3] && $past(!rd_data_o[3]))); // R8

  AST_STROBE_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_clk_en_o |-> core_en_o); // R11

  AST_RESTART_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rd_data_o[2:0]) |-> !core_clk_en_o); // R10

  AST_DIV0_CONT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[2:0] == 3'd0 && $stable(rd_data_o[2:0]) && core_en_o) |-> core_clk_en_o); // R9

endmodule

bind pwr_clk_ctrl pwr_clk_ctrl_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wake_i        (wake_i),
  .rd_data_o     (rd_data_o),
  .core_en_o     (core_en_o),
  .core_clk_en_o (core_clk_en_o)
);

// File: tb/pwr_clk_ctrl_bench.sv
module pwr_clk_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       wake = 1'b0;
  logic [7:0] rd_data;
  logic       prec_en, xtal_en, pll_en, periph_en, core_en, core_clk_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference model state
  int m_reg, m_core_d, m_cnt, m_div_last;

  always #4 clk = ~clk;

  pwr_clk_ctrl u_pwr_clk_ctrl (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .wr_en_i       (wr_en),
    .wr_data_i     (wr_data),
    .wake_i        (wake),
    .rd_data_o     (rd_data),
    .prec_osc_en_o (prec_en),
    .xtal_en_o     (xtal_en),
    .pll_en_o      (pll_en),
    .periph_en_o   (periph_en),
    .core_en_o     (core_en),
    .core_clk_en_o (core_clk_en)
  );

  function automatic int m_div();
    return m_reg & 7;
  endfunction

  function automatic int m_core_out();
    return ((m_reg >> 3) & 1) | m_core_d;
  endfunction

  function automatic int m_strobe();
    int lim;
    lim = (1 << m_div()) - 1;
    return (m_cnt == lim && m_div() == m_div_last && m_core_out() == 1) ? 1 : 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_reg = 'h79; m_core_d = 1; m_cnt = 0; m_div_last = 1;
    end else begin
      int nr, d, cur_p, cur_l, nw_c, nw_p, ok, lim;
      nr = m_reg;
      if (wr_en) begin
        d     = int'(wr_data);
        cur_p = (m_reg >> 4) & 1;
        cur_l = (m_reg >> 5) & 1;
        nw_c  = (d >> 3) & 1;
        nw_p  = (d >> 4) & 1;
        ok = 1;
        if (cur_p == 1 && nw_p == 0 && nw_c == 1) ok = 0;
        if (cur_l == 1 && ((d >> 5) & 1) == 0 && (nw_c == 1 || nw_p == 1)) ok = 0;
        nr = ok ? d : ((d & 'hC7) | (m_reg & 'h38));
      end
      if (wake) nr = nr | 'h38;
      lim = (1 << m_div()) - 1;
      if (m_div() != m_div_last || m_cnt == lim) m_cnt = 0;
      else m_cnt = m_cnt + 1;
      m_div_last = m_div();
      m_core_d = (m_reg >> 3) & 1;
      m_reg = nr;
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R12 rd_data", int'(rd_data), m_reg);
      check("R2 prec_osc", int'(prec_en), (m_reg >> 7) & 1);
      check("R2 xtal", int'(xtal_en), (m_reg >> 6) & 1);
      check("R2 pll", int'(pll_en), (m_reg >> 5) & 1);
      check("R2 periph", int'(periph_en), (m_reg >> 4) & 1);
      check("R8 core_en", int'(core_en), m_core_out());
      check("R9 strobe", int'(core_clk_en), m_strobe());
    end
  end

  task automatic wr(logic [7:0] v);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 20000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    int seen;
    repeat (3) @(negedge clk);
    check("R1 reset rd", int'(rd_data), 'h79);
    check("R1 reset core", int'(core_en), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", int'(rd_data), 'h79);
    repeat (6) @(negedge clk);

    // R3 illegal: periph off with core on; R5 div/osc still applied
    wr(8'h6C);
    check("R3 R5 illegal periph clear", int'(rd_data), 'h7C);
    // R4 illegal: pll off with periph on
    wr(8'h52);
    check("R4 R5 illegal pll clear", int'(rd_data), 'h7A);
    // R3 legal: periph and core off together
    wr(8'h63);
    check("R3 legal clear", int'(rd_data), 'h63);
    check("R8 core held one cycle", int'(core_en), 1);
    @(negedge clk);
    check("R8 core dropped", int'(core_en), 0);
    // R6 wake with periph off
    wake = 1'b1; @(negedge clk); wake = 1'b0;
    check("R6 wake restore", int'(rd_data), 'h7B);
    check("R8 core rises with bit", int'(core_en), 1);
    // legal full shutdown, then R11
    wr(8'h84);
    check("R4 legal pll clear", int'(rd_data), 'h84);
    @(negedge clk);
    seen = 0;
    for (int i = 0; i < 16; i++) begin
      if (core_clk_en) seen++;
      @(negedge clk);
    end
    check("R11 no strobe while off", seen, 0);
    // R7 wake and write collide
    wake = 1'b1; wr_en = 1'b1; wr_data = 8'h41;
    @(negedge clk);
    wake = 1'b0; wr_en = 1'b0;
    check("R7 wake beats write", int'(rd_data), 'h79);
    repeat (5) @(negedge clk);
    // R10 restart after change to code 2
    wr(8'h7A);
    check("R10 quiet on change", int'(core_clk_en), 0);
    for (int i = 1; i <= 8; i++) begin
      @(negedge clk);
      check("R10 R9 strobe timing", int'(core_clk_en), (i % 4 == 0) ? 1 : 0);
    end
    // R9 code 0 continuous, code 7 period
    wr(8'h78);
    repeat (2) @(negedge clk);
    check("R9 code0 strobe", int'(core_clk_en), 1);
    wr(8'h7F);
    seen = 0;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      if (core_clk_en) seen++;
    end
    check("R9 code7 count", seen, 2);
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule